// File: doc/BRIEF.md
# CAN Bus-Off Recovery Sequencer

This block takes a CAN controller through bus-off and back. When the error counters report bus-off, the block sets the controller's initialisation flag by itself, and the bus stays silent. Software must then clear the flag. Clearing it does not restart the controller at once. The block instead watches the sampled receive stream, one sample per bit time, and counts completed idle runs. An idle run is eleven recessive samples in a row. Normal operation resumes only after 129 such runs. At that point the block pulses a reset to the error counters.

Software can follow the recovery through two things. Each completed run writes the Bit0Error code into the last-error-code field of the status word. The count of completed runs is also brought out. An error interrupt flags changes of the bus-off and warning status. A configuration gate allows bit-timing writes only while configuration is enabled and the initialisation flag is set.

The receive stream is a valid-qualified sample input with no back-pressure: the block accepts a sample in every cycle that `smp_vld` is high, and cycles without `smp_vld` leave the run state unchanged. All other pins are plain control and status levels or single-cycle strobes.

Top module: `can_busoff_seq`

## Requirements
- R1: After reset, `status_o` is 16'h0000, `init_o` is 1, `irq_o` is 0, `err_cnt_rst_o` is 0 and `idle_runs_o` is 0.
- R2: A rising edge of `boff_in` sets `init_o` at the next clock edge. The same edge drops `bus_on_o` and clears both the recessive-run count and `idle_runs_o`.
- R3: While halted in bus-off with `init_o` at 1, samples are ignored and `idle_runs_o` stays 0. Recovery starts at the edge after the first cycle in which `init_o` reads 0.
- R4: During recovery, 11 consecutive accepted recessive samples (`smp_rec`=1) complete one run. A completed run increments `idle_runs_o` and writes 3'b101 into `status_o[2:0]`.
- R5: During recovery, an accepted dominant sample (`smp_rec`=0) sets the current recessive run back to zero and leaves `idle_runs_o` unchanged.
- R6: Completion of the 129th run ends recovery. `err_cnt_rst_o` is high for exactly the one following cycle, and `idle_runs_o` returns to 0. `bus_on_o` becomes 1 if `init_o` is 0.
- R7: Setting or clearing `init_o` during recovery does not change the run counts. The point at which recovery completes does not move.
- R8: `status_o[7]`, `[6]` and `[5]` show `boff_in`, `ewarn_in` and `epass_in` with a one-cycle delay. `status_o[15:8]` is always zero.
- R9: With the interrupt enable written to 1, a change of `boff_in` or `ewarn_in` sets `irq_o` at the next edge. With the enable at 0, such a change leaves `irq_o` at 0.
- R10: `irq_o` stays high until an `irq_clr` strobe. A status change in the same cycle as `irq_clr` leaves `irq_o` high.
- R11: `btr_wr_en_o` is high only when `btr_wr_req` is high, the configuration enable is 1 and `init_o` is 1.
- R12: `rxok_set` and `txok_set` set `status_o[4]` and `status_o[3]`. `stat_ack` clears both bits and sets `status_o[2:0]` to 0. A `lec_evt_vld` event writes `lec_evt_code` into `status_o[2:0]` only in normal operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_vld | input | 1 | A receive sample is present this cycle |
| smp_rec | input | 1 | Sample level, 1 = recessive |
| boff_in | input | 1 | Bus-off level from error counters |
| ewarn_in | input | 1 | Warning level from error counters |
| epass_in | input | 1 | Error-passive level from error counters |
| rxok_set | input | 1 | Strobe: frame received correctly |
| txok_set | input | 1 | Strobe: frame sent correctly |
| lec_evt_vld | input | 1 | Strobe: frame logic reports an error code |
| lec_evt_code | input | 3 | Error code reported by frame logic |
| stat_ack | input | 1 | Strobe: software clears the ok bits and error code |
| cpu_init_set | input | 1 | Strobe: software sets the initialisation flag |
| cpu_init_clr | input | 1 | Strobe: software clears the initialisation flag |
| ctrl_wr | input | 1 | Strobe: write the control enables |
| ctrl_eie | input | 1 | Interrupt enable value for `ctrl_wr` |
| ctrl_cce | input | 1 | Configuration enable value for `ctrl_wr` |
| irq_clr | input | 1 | Strobe: clear the error interrupt |
| btr_wr_req | input | 1 | Software requests a bit-timing write |
| init_o | output | 1 | Initialisation flag |
| bus_on_o | output | 1 | Controller may take part in bus traffic |
| status_o | output | 16 | Status word |
| irq_o | output | 1 | Error interrupt |
| err_cnt_rst_o | output | 1 | One-cycle reset to the error counters |
| idle_runs_o | output | 8 | Completed idle runs in the current recovery |
| btr_wr_en_o | output | 1 | Bit-timing write is permitted |

## Verification
The run and idle counters can go wrong in three ways: an off-by-one, a dominant sample that clears the idle count, or samples accepted while halted. Each of these changes `idle_runs_o` or `status_o[2:0]` on the very next accepted sample. A wrong completion count moves the `err_cnt_rst_o` pulse by at least eleven samples. A phase register that skips the halt state raises `bus_on_o` while `init_o` is still needed. A faulty interrupt latch shows one cycle after a `boff_in` or `ewarn_in` change or after `irq_clr`. The bench therefore compares every output on every cycle, so each of these faults shows up within one cycle of the stimulus that exposes it.

// File: rtl/can_bo_pkg.sv
`timescale 1ns/1ps
package can_bo_pkg;

  typedef enum logic [1:0] {
    PH_NORMAL  = 2'd0,
    PH_HALT    = 2'd1,
    PH_RECOVER = 2'd2
  } bo_phase_e;

  localparam int          LEC_W        = 3;
  localparam logic [2:0]  LEC_BIT0ERR  = 3'b101;
  localparam logic [2:0]  LEC_NONE     = 3'b000;

  localparam int STAT_W      = 16;
  localparam int POS_BOFF    = 7;
  localparam int POS_EWARN   = 6;
  localparam int POS_EPASS   = 5;
  localparam int POS_RXOK    = 4;
  localparam int POS_TXOK    = 3;

endpackage

// File: rtl/can_bo_runcnt.sv
`timescale 1ns/1ps
module can_bo_runcnt #(
  parameter int RUN_LEN     = 11,
  parameter int IDLE_TARGET = 129,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear,
  input  logic             active,
  input  logic             smp_vld,
  input  logic             smp_rec,
  output logic             run_done,
  output logic             seq_done,
  output logic [CNT_W-1:0] idle_cnt
);

  localparam int RUN_W = $clog2(RUN_LEN);
  localparam logic [RUN_W-1:0] RUN_LAST  = RUN_W'(RUN_LEN - 1);
  localparam logic [CNT_W-1:0] IDLE_LAST = CNT_W'(IDLE_TARGET - 1);

  logic [RUN_W-1:0] run_q;
  logic [CNT_W-1:0] idle_q;
  logic             take;

  assign take     = active && smp_vld && !clear;
  assign run_done = take && smp_rec && (run_q == RUN_LAST);
  assign seq_done = run_done && (idle_q == IDLE_LAST);
  assign idle_cnt = idle_q;

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      run_q  <= '0;
      idle_q <= '0;
    end else if (take) begin
      if (!smp_rec) begin
        run_q <= '0;
      end else if (run_done) begin
        run_q  <= '0;
        idle_q <= seq_done ? '0 : idle_q + 1'b1;
      end else begin
        run_q <= run_q + 1'b1;
      end
    end
  end

  AST_RUN_BELOW_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= RUN_LAST); // R4
  AST_IDLE_BELOW_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    idle_q <= IDLE_LAST); // R6
  AST_DOMINANT_CLEARS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !smp_rec) |=> (run_q == '0)); // R5
  AST_DOMINANT_KEEPS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !smp_rec) |=> $stable(idle_q)); // R5
  AST_IDLE_FROZEN_WHEN_INACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && !clear) |=> $stable(idle_q)); // R3

endmodule

// File: rtl/can_bo_ctrl.sv
`timescale 1ns/1ps
module can_bo_ctrl
  import can_bo_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      boff_rise,
  input  logic      cpu_init_set,
  input  logic      cpu_init_clr,
  input  logic      seq_done,
  output logic      init_o,
  output bo_phase_e phase_o
);

  logic      init_q;
  bo_phase_e phase_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      init_q <= 1'b1;
    end else if (boff_rise || cpu_init_set) begin
      init_q <= 1'b1;
    end else if (cpu_init_clr) begin
      init_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase_q <= PH_NORMAL;
    end else if (boff_rise) begin
      phase_q <= PH_HALT;
    end else begin
      case (phase_q)
        PH_HALT:    if (!init_q)  phase_q <= PH_RECOVER;
        PH_RECOVER: if (seq_done) phase_q <= PH_NORMAL;
        default:    phase_q <= phase_q;
      endcase
    end
  end

  assign init_o  = init_q;
  assign phase_o = phase_q;

  AST_INIT_ON_BOFF: assert property (@(posedge clk) disable iff (!rst_n)
    boff_rise |=> (init_q && phase_q == PH_HALT)); // R2
  AST_HALT_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HALT && init_q) |=> (phase_q != PH_RECOVER)); // R3
  AST_RECOVER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_RECOVER && !seq_done && !boff_rise) |=> (phase_q == PH_RECOVER)); // R7

endmodule

// File: rtl/can_bo_status.sv
`timescale 1ns/1ps
module can_bo_status
  import can_bo_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boff_in,
  input  logic              ewarn_in,
  input  logic              epass_in,
  input  logic              rxok_set,
  input  logic              txok_set,
  input  logic              stat_ack,
  input  logic              lec_evt_vld,
  input  logic              lec_evt_ok,
  input  logic [LEC_W-1:0]  lec_evt_code,
  input  logic              run_done,
  input  logic              ctrl_wr,
  input  logic              ctrl_eie,
  input  logic              ctrl_cce,
  input  logic              irq_clr,
  output logic [STAT_W-1:0] status_o,
  output logic              irq_o,
  output logic              cce_o,
  output logic              boff_rise_o
);

  logic             boff_q, ewarn_q, epass_q, rxok_q, txok_q;
  logic [LEC_W-1:0] lec_q;
  logic             eie_q, cce_q, irq_q;
  logic             stat_chg;

  assign boff_rise_o = boff_in && !boff_q;
  assign stat_chg    = (boff_in != boff_q) || (ewarn_in != ewarn_q);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      boff_q  <= 1'b0;
      ewarn_q <= 1'b0;
      epass_q <= 1'b0;
    end else begin
      boff_q  <= boff_in;
      ewarn_q <= ewarn_in;
      epass_q <= epass_in;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rxok_q <= 1'b0;
      txok_q <= 1'b0;
    end else begin
      if (rxok_set)      rxok_q <= 1'b1;
      else if (stat_ack) rxok_q <= 1'b0;
      if (txok_set)      txok_q <= 1'b1;
      else if (stat_ack) txok_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lec_q <= LEC_NONE;
    end else if (run_done) begin
      lec_q <= LEC_BIT0ERR;
    end else if (lec_evt_vld && lec_evt_ok) begin
      lec_q <= lec_evt_code;
    end else if (stat_ack) begin
      lec_q <= LEC_NONE;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      eie_q <= 1'b0;
      cce_q <= 1'b0;
    end else if (ctrl_wr) begin
      eie_q <= ctrl_eie;
      cce_q <= ctrl_cce;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q <= 1'b0;
    end else if (eie_q && stat_chg) begin
      irq_q <= 1'b1;
    end else if (irq_clr) begin
      irq_q <= 1'b0;
    end
  end

  always_comb begin
    status_o            = '0;
    status_o[POS_BOFF]  = boff_q;
    status_o[POS_EWARN] = ewarn_q;
    status_o[POS_EPASS] = epass_q;
    status_o[POS_RXOK]  = rxok_q;
    status_o[POS_TXOK]  = txok_q;
    status_o[LEC_W-1:0] = lec_q;
  end

  assign irq_o = irq_q;
  assign cce_o = cce_q;

  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !irq_clr) |=> irq_q); // R10
  AST_NO_IRQ_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (!eie_q && !irq_q) |=> !irq_q); // R9
  AST_BIT0_LOGGED: assert property (@(posedge clk) disable iff (!rst_n)
    run_done |=> (lec_q == LEC_BIT0ERR)); // R4
  AST_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_o[STAT_W-1:8] == '0); // R8

endmodule

// File: rtl/can_busoff_seq.sv
`timescale 1ns/1ps
module can_busoff_seq
  import can_bo_pkg::*;
#(
  parameter int RUN_LEN     = 11,
  parameter int IDLE_TARGET = 129,
  parameter int CNT_W       = 8
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        smp_vld,
  input  logic        smp_rec,
  input  logic        boff_in,
  input  logic        ewarn_in,
  input  logic        epass_in,
  input  logic        rxok_set,
  input  logic        txok_set,
  input  logic        lec_evt_vld,
  input  logic [2:0]  lec_evt_code,
  input  logic        stat_ack,
  input  logic        cpu_init_set,
  input  logic        cpu_init_clr,
  input  logic        ctrl_wr,
  input  logic        ctrl_eie,
  input  logic        ctrl_cce,
  input  logic        irq_clr,
  input  logic        btr_wr_req,
  output logic        init_o,
  output logic        bus_on_o,
  output logic [15:0] status_o,
  output logic        irq_o,
  output logic        err_cnt_rst_o,
  output logic [7:0]  idle_runs_o,
  output logic        btr_wr_en_o
);

  bo_phase_e        phase;
  logic             boff_rise, run_done, seq_done, cce, init;
  logic [CNT_W-1:0] idle_cnt;
  logic             err_rst_q;

  can_bo_status u_status (
    .clk          (clk),
    .rst_n        (rst_n),
    .boff_in      (boff_in),
    .ewarn_in     (ewarn_in),
    .epass_in     (epass_in),
    .rxok_set     (rxok_set),
    .txok_set     (txok_set),
    .stat_ack     (stat_ack),
    .lec_evt_vld  (lec_evt_vld),
    .lec_evt_ok   (phase == PH_NORMAL),
    .lec_evt_code (lec_evt_code),
    .run_done     (run_done),
    .ctrl_wr      (ctrl_wr),
    .ctrl_eie     (ctrl_eie),
    .ctrl_cce     (ctrl_cce),
    .irq_clr      (irq_clr),
    .status_o     (status_o),
    .irq_o        (irq_o),
    .cce_o        (cce),
    .boff_rise_o  (boff_rise)
  );

  can_bo_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .boff_rise    (boff_rise),
    .cpu_init_set (cpu_init_set),
    .cpu_init_clr (cpu_init_clr),
    .seq_done     (seq_done),
    .init_o       (init),
    .phase_o      (phase)
  );

  can_bo_runcnt #(
    .RUN_LEN     (RUN_LEN),
    .IDLE_TARGET (IDLE_TARGET),
    .CNT_W       (CNT_W)
  ) u_runcnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (boff_rise),
    .active   (phase == PH_RECOVER),
    .smp_vld  (smp_vld),
    .smp_rec  (smp_rec),
    .run_done (run_done),
    .seq_done (seq_done),
    .idle_cnt (idle_cnt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) err_rst_q <= 1'b0;
    else        err_rst_q <= seq_done;
  end

  assign init_o        = init;
  assign bus_on_o      = (phase == PH_NORMAL) && !init;
  assign err_cnt_rst_o = err_rst_q;
  assign idle_runs_o   = 8'(idle_cnt);
  assign btr_wr_en_o   = btr_wr_req && cce && init;

  AST_CNT_RST_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    err_rst_q |=> !err_rst_q); // R6
  AST_CNT_RST_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    err_rst_q |-> (phase == PH_NORMAL && idle_cnt == '0)); // R6
  AST_BUS_OFF_WHEN_HALTED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_NORMAL) |-> !bus_on_o); // R2

endmodule

// File: tb/can_busoff_seq_tb_top.sv
`timescale 1ns/1ps
module can_busoff_seq_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic smp_vld = 0, smp_rec = 0, boff_in = 0, ewarn_in = 0, epass_in = 0;
  logic rxok_set = 0, txok_set = 0, lec_evt_vld = 0, stat_ack = 0;
  logic [2:0] lec_evt_code = 3'd0;
  logic cpu_init_set = 0, cpu_init_clr = 0, ctrl_wr = 0, ctrl_eie = 0, ctrl_cce = 0;
  logic irq_clr = 0, btr_wr_req = 0;
  logic init_o, bus_on_o, irq_o, err_cnt_rst_o, btr_wr_en_o;
  logic [15:0] status_o;
  logic [7:0]  idle_runs_o;

  int total = 0;
  int fails = 0;

  always #10 clk = ~clk;

  can_busoff_seq dut_i (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_rec(smp_rec),
    .boff_in(boff_in), .ewarn_in(ewarn_in), .epass_in(epass_in),
    .rxok_set(rxok_set), .txok_set(txok_set), .lec_evt_vld(lec_evt_vld),
    .lec_evt_code(lec_evt_code), .stat_ack(stat_ack),
    .cpu_init_set(cpu_init_set), .cpu_init_clr(cpu_init_clr),
    .ctrl_wr(ctrl_wr), .ctrl_eie(ctrl_eie), .ctrl_cce(ctrl_cce),
    .irq_clr(irq_clr), .btr_wr_req(btr_wr_req),
    .init_o(init_o), .bus_on_o(bus_on_o), .status_o(status_o), .irq_o(irq_o),
    .err_cnt_rst_o(err_cnt_rst_o), .idle_runs_o(idle_runs_o),
    .btr_wr_en_o(btr_wr_en_o)
  );

  // behavioural reference state; phase: 0 normal, 1 halted, 2 recovering
  int m_init = 1, m_phase = 0, m_run = 0, m_idle = 0;
  int m_boff = 0, m_ewarn = 0, m_epass = 0, m_rxok = 0, m_txok = 0, m_lec = 0;
  int m_irq = 0, m_eie = 0, m_cce = 0, m_pulse = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    int n_init, n_phase, n_run, n_idle, n_lec, n_irq;
    bit rise, drun, dseq;
    if (!rst_n) begin
      m_init = 1; m_phase = 0; m_run = 0; m_idle = 0; m_boff = 0; m_ewarn = 0;
      m_epass = 0; m_rxok = 0; m_txok = 0; m_lec = 0; m_irq = 0; m_eie = 0;
      m_cce = 0; m_pulse = 0;
    end else begin
      rise = boff_in && (m_boff == 0);
      drun = 0; dseq = 0;
      n_init = m_init;
      if (rise || cpu_init_set) n_init = 1;
      else if (cpu_init_clr) n_init = 0;
      n_phase = m_phase; n_run = m_run; n_idle = m_idle;
      if (rise) begin
        n_phase = 1; n_run = 0; n_idle = 0;
      end else if (m_phase == 1) begin
        if (m_init == 0) n_phase = 2;
      end else if (m_phase == 2 && smp_vld) begin
        if (!smp_rec) n_run = 0;
        else if (m_run == 10) begin
          drun = 1; n_run = 0;
          if (m_idle == 128) begin dseq = 1; n_idle = 0; n_phase = 0; end
          else n_idle = m_idle + 1;
        end else n_run = m_run + 1;
      end
      n_lec = m_lec;
      if (drun) n_lec = 5;
      else if (lec_evt_vld && m_phase == 0) n_lec = int'(lec_evt_code);
      else if (stat_ack) n_lec = 0;
      if (rxok_set) m_rxok = 1; else if (stat_ack) m_rxok = 0;
      if (txok_set) m_txok = 1; else if (stat_ack) m_txok = 0;
      n_irq = m_irq;
      if (m_eie != 0 && ((int'(boff_in) != m_boff) || (int'(ewarn_in) != m_ewarn))) n_irq = 1;
      else if (irq_clr) n_irq = 0;
      if (ctrl_wr) begin m_eie = int'(ctrl_eie); m_cce = int'(ctrl_cce); end
      m_boff = int'(boff_in); m_ewarn = int'(ewarn_in); m_epass = int'(epass_in);
      m_init = n_init; m_phase = n_phase; m_run = n_run; m_idle = n_idle;
      m_lec = n_lec; m_irq = n_irq; m_pulse = int'(dseq);
    end
  end

  // per-cycle comparison, away from the edge
  always begin
    int exp_stat, exp_btr, exp_on;
    @(posedge clk);
    #5;
    if (rst_n) begin
      exp_stat = (m_boff << 7) | (m_ewarn << 6) | (m_epass << 5) | (m_rxok << 4) |
                 (m_txok << 3) | m_lec;
      exp_btr  = (btr_wr_req && m_cce != 0 && m_init != 0) ? 1 : 0;
      exp_on   = (m_phase == 0 && m_init == 0) ? 1 : 0;
      chk(int'(init_o) == m_init, "R2 init_o", int'(init_o), m_init);
      chk(int'(status_o) == exp_stat, "R8 status_o", int'(status_o), exp_stat);
      chk(int'(idle_runs_o) == m_idle, "R4 idle_runs_o", int'(idle_runs_o), m_idle);
      chk(int'(irq_o) == m_irq, "R9 irq_o", int'(irq_o), m_irq);
      chk(int'(err_cnt_rst_o) == m_pulse, "R6 err_cnt_rst_o", int'(err_cnt_rst_o), m_pulse);
      chk(int'(bus_on_o) == exp_on, "R6 bus_on_o", int'(bus_on_o), exp_on);
      chk(int'(btr_wr_en_o) == exp_btr, "R11 btr_wr_en_o", int'(btr_wr_en_o), exp_btr);
    end
  end

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic strobe(ref logic s);
    s = 1'b1; tick(); s = 1'b0;
  endtask

  task automatic send(input bit r);
    smp_vld = 1'b1; smp_rec = r; tick(); smp_vld = 1'b0; tick();
  endtask

  task automatic send_runs(input int n);
    for (int i = 0; i < n * 11; i++) send(1'b1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    total++; fails++;
    $display("FAIL R6 watchdog expired actual=0 expected=1");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    tick(4);
    rst_n = 1'b1;
    tick();
    // R1 reset state
    chk(status_o == 16'h0000, "R1 status reset", int'(status_o), 0);
    chk(init_o == 1'b1 && irq_o == 1'b0, "R1 init/irq reset", {init_o, irq_o}, 2);
    chk(idle_runs_o == 8'd0 && !err_cnt_rst_o, "R1 idle reset", int'(idle_runs_o), 0);
    // R11 gate closed without configuration enable
    btr_wr_req = 1'b1; #1;
    chk(btr_wr_en_o == 1'b0, "R11 cce=0 blocks", int'(btr_wr_en_o), 0);
    ctrl_eie = 1'b1; ctrl_cce = 1'b1; strobe(ctrl_wr); #1;
    chk(btr_wr_en_o == 1'b1, "R11 cce=1 init=1 allows", int'(btr_wr_en_o), 1);
    strobe(cpu_init_clr); #1;
    chk(btr_wr_en_o == 1'b0 && bus_on_o, "R11 init=0 blocks", int'(btr_wr_en_o), 0);
    btr_wr_req = 1'b0;
    // R12 normal-phase status
    lec_evt_code = 3'd3; strobe(lec_evt_vld);
    strobe(rxok_set); strobe(txok_set);
    chk(status_o[4:0] == 5'b11011, "R12 ok bits and code", int'(status_o[4:0]), 5'b11011);
    strobe(stat_ack);
    chk(status_o[4:0] == 5'b0, "R12 ack clears", int'(status_o[4:0]), 0);
    // R9 / R10 interrupt
    ewarn_in = 1'b1; epass_in = 1'b1; tick();
    chk(irq_o == 1'b1, "R9 ewarn change raises irq", int'(irq_o), 1);
    chk(status_o[6:5] == 2'b11, "R8 ewarn/epass positions", int'(status_o[6:5]), 3);
    tick(3);
    chk(irq_o == 1'b1, "R10 irq held", int'(irq_o), 1);
    ewarn_in = 1'b0; irq_clr = 1'b1; tick(); irq_clr = 1'b0;
    chk(irq_o == 1'b1, "R10 change with clear keeps irq", int'(irq_o), 1);
    strobe(irq_clr);
    chk(irq_o == 1'b0, "R10 clear drops irq", int'(irq_o), 0);
    // R2 bus-off entry
    boff_in = 1'b1; tick();
    chk(init_o == 1'b1 && !bus_on_o, "R2 bus-off sets init", int'(init_o), 1);
    chk(status_o[7] == 1'b1, "R8 boff position", int'(status_o[7]), 1);
    strobe(irq_clr);
    // R3 halted: samples ignored, frame codes ignored
    send_runs(3);
    lec_evt_code = 3'd2; strobe(lec_evt_vld);
    chk(idle_runs_o == 8'd0, "R3 halted ignores samples", int'(idle_runs_o), 0);
    chk(status_o[2:0] == 3'd0, "R12 code ignored when halted", int'(status_o[2:0]), 0);
    strobe(cpu_init_set);
    strobe(cpu_init_clr);
    tick();
    // R4 first run
    send_runs(1);
    chk(idle_runs_o == 8'd1 && status_o[2:0] == 3'b101, "R4 run completes", int'(idle_runs_o), 1);
    // R5 dominant interrupts partial run
    for (int i = 0; i < 7; i++) send(1'b1);
    send(1'b0);
    chk(idle_runs_o == 8'd1, "R5 dominant keeps idle count", int'(idle_runs_o), 1);
    for (int i = 0; i < 10; i++) send(1'b1);
    chk(idle_runs_o == 8'd1, "R5 run restarted", int'(idle_runs_o), 1);
    send(1'b1);
    chk(idle_runs_o == 8'd2, "R5 run after dominant", int'(idle_runs_o), 2);
    // R7 init toggles do not shorten
    strobe(cpu_init_set);
    send_runs(1);
    strobe(cpu_init_clr);
    chk(idle_runs_o == 8'd3, "R7 count unaffected by init", int'(idle_runs_o), 3);
    send_runs(125);
    for (int i = 0; i < 10; i++) send(1'b1);
    chk(idle_runs_o == 8'd128 && !err_cnt_rst_o && !bus_on_o, "R7 not done early", int'(idle_runs_o), 128);
    smp_vld = 1'b1; smp_rec = 1'b1; tick(); smp_vld = 1'b0;
    chk(err_cnt_rst_o == 1'b1, "R6 counter reset pulse", int'(err_cnt_rst_o), 1);
    chk(idle_runs_o == 8'd0 && bus_on_o, "R6 normal resumes", int'(idle_runs_o), 0);
    tick();
    chk(err_cnt_rst_o == 1'b0, "R6 pulse single cycle", int'(err_cnt_rst_o), 0);
    // R9 disabled interrupt
    ctrl_eie = 1'b0; ctrl_cce = 1'b0; strobe(ctrl_wr);
    strobe(irq_clr);
    boff_in = 1'b0; tick(2);
    chk(irq_o == 1'b0, "R9 enable=0 no irq", int'(irq_o), 0);
    boff_in = 1'b1; tick(2);
    chk(irq_o == 1'b0 && init_o, "R9 enable=0 bus-off no irq", int'(irq_o), 0);
    tick(3);
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule